// File: doc/BRIEF.md
# Self-Routing Banyan Switch Fabric

An 8x8 multistage interconnect made of twelve 2x2 switching elements arranged as three stages of four. Every input port may present one packet per cycle: a valid bit, a 3-bit destination tag and a payload. There is no central controller. Each element looks at a single tag bit and steers the packet onward. A perfect-shuffle permutation ahead of every stage ensures that a packet which survives all three stages leaves on the output port whose number equals its tag.

Unlike a crossbar, two packets can compete for the same internal link even when their final destinations differ. The fabric resolves such a conflict inside the element. The packet on the element's upper input keeps the link. The other packet is discarded, and a drop flag is raised for the input port it came from. The datapath is combinational. An optional register stage can be placed on the outputs and drop flags, in which case every result appears one clock later.

Top module: `banyan_fabric`

## Requirements
- R1: A valid packet that is not dropped leaves on output port number equal to its tag, with its payload unchanged. With REG_OUT=0 it appears in the same cycle. With REG_OUT=1 it appears after the next rising clock edge.
- R2: The three stages read the tag bits in order: bit 2 first, then bit 1, then bit 0. A 0 bit takes the element's upper output (even link) and a 1 bit takes the lower output (odd link). Each stage is preceded by a perfect shuffle, which moves link p to the link given by rotating p left by one bit. Two packets that want the same link collide even when their tags differ. For example, inputs 0 and 4 carrying tags 0 and 1 meet in element 0 of the first stage.
- R3: When two packets collide, the one on the element's upper (even) input wins. The loser is removed, and drop bit i is set for its source port i, with the same latency as the outputs.
- R4: An input whose valid bit is 0 uses no link. When every input is invalid, all outputs and drop flags are 0. An invalid input never causes a valid packet to be dropped.
- R5: When all eight inputs are valid and input i carries tag i, all eight packets are delivered and no drop flag is set.
- R6: For every input pattern, the number of valid outputs plus the number of set drop flags equals the number of valid inputs.
- R7: With REG_OUT=1, the outputs and drop flags are 0 while reset is asserted and just after it is released.
- R8: A drop flag is never set for an input whose valid bit was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when REG_OUT=1 |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| in_valid | input | 8 | Per-input packet present |
| in_tag | input | 8x3 | Per-input destination tag |
| in_data | input | 8xPW | Per-input payload |
| out_valid | output | 8 | Per-output packet present |
| out_data | output | 8xPW | Per-output payload |
| drop | output | 8 | Per-input flag: packet lost in a collision |

## Verification
The bench builds two copies of the fabric with LOG2N=3 and PW=8, one with REG_OUT=0 and one with REG_OUT=1, and drives both with the same stimulus. The combinational copy exposes the same-cycle relation between collisions and drop flags. The registered copy covers the reset state and the one-cycle latency. The 8-bit payload is large enough to tell packets apart, so a packet routed to the wrong port is visible. Random traffic with varied load, together with directed cases, is compared against a model that finds collisions from the closed-form link position of each packet at each stage.

// File: rtl/banyan_fabric.sv
module banyan_fabric #(
  parameter int LOG2N   = 3,
  parameter int PW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [(1<<LOG2N)-1:0]             in_valid,
  input  logic [(1<<LOG2N)-1:0][LOG2N-1:0]  in_tag,
  input  logic [(1<<LOG2N)-1:0][PW-1:0]     in_data,
  output logic [(1<<LOG2N)-1:0]             out_valid,
  output logic [(1<<LOG2N)-1:0][PW-1:0]     out_data,
  output logic [(1<<LOG2N)-1:0]             drop
);
  localparam int N = 1 << LOG2N;
  localparam int H = N / 2;

  typedef struct packed {
    logic             v;
    logic [LOG2N-1:0] tag;
    logic [LOG2N-1:0] src;
    logic [PW-1:0]    data;
  } lane_t;

  lane_t             cur [N];
  lane_t             sh  [N];
  logic [N-1:0]      c_valid, c_drop;
  logic [N-1:0][PW-1:0] c_data;

  function automatic logic [LOG2N-1:0] rotl(input logic [LOG2N-1:0] x);
    return {x[LOG2N-2:0], x[LOG2N-1]};
  endfunction

  always_comb begin
    c_drop = '0;
    for (int p = 0; p < N; p++)
      cur[p] = '{v: in_valid[p], tag: in_tag[p], src: LOG2N'(p), data: in_data[p]};
    for (int s = 0; s < LOG2N; s++) begin
      for (int p = 0; p < N; p++) sh[rotl(LOG2N'(p))] = cur[p];
      for (int p = 0; p < N; p++) cur[p] = '0;
      for (int k = 0; k < H; k++) begin
        logic bu, bl;
        bu = sh[2*k].tag[LOG2N-1-s];
        bl = sh[2*k+1].tag[LOG2N-1-s];
        if (sh[2*k].v) cur[2*k + int'(bu)] = sh[2*k];
        if (sh[2*k+1].v) begin
          if (sh[2*k].v && bu == bl) c_drop[sh[2*k+1].src] = 1'b1;
          else cur[2*k + int'(bl)] = sh[2*k+1];
        end
      end
    end
    for (int p = 0; p < N; p++) begin
      c_valid[p] = cur[p].v;
      c_data[p]  = cur[p].data;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= '0;
          out_data  <= '0;
          drop      <= '0;
        end else begin
          out_valid <= c_valid;
          out_data  <= c_data;
          drop      <= c_drop;
        end
      end
    end else begin : g_comb
      assign out_valid = c_valid;
      assign out_data  = c_data;
      assign drop      = c_drop;
    end
  endgenerate
endmodule

// File: rtl/banyan_fabric_chk.sv
module banyan_fabric_chk #(
  parameter int LOG2N   = 3,
  parameter int PW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [(1<<LOG2N)-1:0]             in_valid,
  input logic [(1<<LOG2N)-1:0][LOG2N-1:0]  in_tag,
  input logic [(1<<LOG2N)-1:0]             out_valid,
  input logic [(1<<LOG2N)-1:0]             drop
);
  localparam int N = 1 << LOG2N;
  logic [N-1:0] want, r_want, r_valid;

  always_comb begin
    want = '0;
    for (int i = 0; i < N; i++)
      if (in_valid[i]) want[in_tag[i]] = 1'b1;
  end

  generate
    if (REG_OUT) begin : g_d
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r_want  <= '0;
          r_valid <= '0;
        end else begin
          r_want  <= want;
          r_valid <= in_valid;
        end
      end
    end else begin : g_n
      assign r_want  = want;
      assign r_valid = in_valid;
    end
  endgenerate

  assert_out_wanted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & ~r_want) == '0);
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid == '0 |-> (out_valid == '0 && drop == '0));
  assert_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) + $countones(drop) == $countones(r_valid));
  assert_drop_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop & ~r_valid) == '0);
endmodule

bind banyan_fabric banyan_fabric_chk #(.LOG2N(LOG2N), .PW(PW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
  .out_valid(out_valid), .drop(drop));

// File: tb/banyan_fabric_tb.sv
`timescale 1ns/1ps
module banyan_fabric_tb;
  localparam int LOG2N = 3;
  localparam int N = 8;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] iv;
  logic [N-1:0][LOG2N-1:0] it;
  logic [N-1:0][PW-1:0] id;
  logic [N-1:0] rv, cv, rdr, cdr;
  logic [N-1:0][PW-1:0] rd, cd;
  logic [N-1:0] ev, edr;
  logic [N-1:0][PW-1:0] ed;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  banyan_fabric #(.LOG2N(LOG2N), .PW(PW), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_tag(it), .in_data(id),
    .out_valid(rv), .out_data(rd), .drop(rdr));
  banyan_fabric #(.LOG2N(LOG2N), .PW(PW), .REG_OUT(1'b0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_tag(it), .in_data(id),
    .out_valid(cv), .out_data(cd), .drop(cdr));

  // position of packet from input i with tag t after stage s (0-based)
  function automatic int link_pos(int i, int t, int s);
    return ((i << (s + 1)) & (N - 1)) | (t >> (LOG2N - 1 - s));
  endfunction

  function automatic void model();
    logic [N-1:0] alive = iv;
    ev = '0; ed = '0; edr = '0;
    for (int s = 0; s < LOG2N; s++)
      for (int i = 0; i < N; i++)
        for (int j = i + 1; j < N; j++)
          if (alive[i] && alive[j] && link_pos(i, int'(it[i]), s) == link_pos(j, int'(it[j]), s)) begin
            if (((i >> (LOG2N - 1 - s)) & 1) == 1) begin alive[i] = 1'b0; edr[i] = 1'b1; end
            else begin alive[j] = 1'b0; edr[j] = 1'b1; end
          end
    for (int i = 0; i < N; i++)
      if (alive[i]) begin ev[it[i]] = 1'b1; ed[it[i]] = id[i]; end
  endfunction

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic cmp(string tag, logic [N-1:0] v, logic [N-1:0][PW-1:0] d, logic [N-1:0] dr);
    logic [N-1:0][PW-1:0] md = '0;
    for (int p = 0; p < N; p++) if (ev[p]) md[p] = d[p];
    chk("R1", {tag, " out_valid"}, 64'(v), 64'(ev));
    chk("R1", {tag, " out_data"}, 64'(md), 64'(ed));
    chk("R2", {tag, " drop"}, 64'(dr), 64'(edr));
    chk("R8", {tag, " drop on idle input"}, 64'(dr & ~iv), 64'd0);
    chk("R6", {tag, " conservation"}, 64'($countones(v) + $countones(dr)), 64'($countones(iv)));
  endtask

  task automatic apply();
    #1;
    model();
    cmp("comb", cv, cd, cdr);
    @(posedge clk); #1;
    cmp("reg", rv, rd, rdr);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: got=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0bad));
    iv = '0; it = '0; id = '0;
    repeat (3) @(negedge clk);
    chk("R7", "reg out_valid in reset", 64'(rv), 64'd0);
    chk("R7", "reg drop in reset", 64'(rdr), 64'd0);
    iv = 8'hff;
    for (int i = 0; i < N; i++) begin it[i] = 3'(7 - i); id[i] = 8'(i + 1); end
    rst_n = 1'b1;
    #1;
    chk("R7", "reg out_valid after release", 64'(rv), 64'd0);
    @(negedge clk);

    // R4: idle
    iv = '0; apply();
    chk("R4", "idle out", 64'(cv | cdr), 64'd0);

    // R5: identity, sorted
    iv = 8'hff;
    for (int i = 0; i < N; i++) begin it[i] = 3'(i); id[i] = 8'(8'h40 + i); end
    apply();
    chk("R5", "identity drops", 64'(cdr), 64'd0);
    chk("R5", "identity valid", 64'(cv), 64'hff);

    // R2 and R3: inputs 0 and 4, tags 0 and 1, collide in stage one
    iv = 8'b0001_0001; it = '0; it[0] = 3'd0; it[4] = 3'd1; id[0] = 8'hA0; id[4] = 8'hA4;
    apply();
    chk("R3", "upper wins drop", 64'(cdr), 64'h10);
    chk("R3", "upper wins out", 64'(cv), 64'h01);
    chk("R3", "winner payload", 64'(cd[0]), 64'hA0);

    // R4: invalid input 0 does not block input 4
    iv = 8'b0001_0000; apply();
    chk("R4", "invalid no conflict drop", 64'(cdr), 64'd0);
    chk("R4", "invalid no conflict out", 64'(cv), 64'h02);

    // all to one port
    iv = 8'hff; for (int i = 0; i < N; i++) begin it[i] = 3'd5; id[i] = 8'(i); end
    apply();
    chk("R6", "hotspot one survivor", 64'($countones(cv)), 64'd1);

    // reverse permutation
    for (int i = 0; i < N; i++) it[i] = 3'(7 - i);
    apply();

    for (int n = 0; n < 400; n++) begin
      int load = n % 4;
      for (int i = 0; i < N; i++) begin
        iv[i] = (($urandom % 4) <= load);
        it[i] = 3'($urandom);
        id[i] = 8'($urandom);
      end
      apply();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule